// File: doc/BRIEF.md
# Bus-Free Detection and Arbitration Controller

This block acquires a shared 16-bit parallel bus for one attached device. The bus has active-low BUSY and SELECT control lines and active-low data lines with wired-OR behaviour. The block watches both control lines, and it declares the bus idle only after both have stayed released for a programmable number of clock cycles. When the local sequencer raises a request on an idle bus, the block pulls BUSY low together with the single data line that carries the device's own identifier. It waits a programmable arbitration window. It then reads the data lines to find out whether any contender of higher rank was present.

The winner reports a grant to the sequencer and keeps holding its lines until the request is withdrawn. A loser lets go of everything at once and goes back to watching the bus. A fairness register stops a device that keeps winning from starving the others. When the device wins, it notes every lower-ranked contender it saw. While any noted identifier remains, the device holds back its next request. The device removes an identifier from the register when it watches that identifier win an arbitration among other devices.

All delays are clock-cycle counts set by parameters. The block's outputs are drive enables: a 1 pulls the matching bus line to its asserted (low) level.

Top module: `busArbiter`

## Requirements
- R1: The bus counts as free only after BUSY and SELECT have both been sampled high (released) on SETTLE_CYC consecutive clock edges. With a request pending, the drive enables rise on edge SETTLE_CYC+1 after the lines are released. A single cycle in which either line is low restarts the count.
- R2: All bus lines are active low. An input at 0 means the line is asserted. A drive-enable output at 1 means the block pulls that line low.
- R3: Arbitration begins in one cycle. `bsyDrvEn` goes to 1 and `dbDrvEn` becomes a one-hot value with bit `ownId` set. No data drive is ever active without `bsyDrvEn`.
- R4: The block takes its priority decision from the data lines ARB_CYC cycles after its own assertion. The drive enables stay on, and the grant stays off, for ARB_CYC+1 cycles of arbitration.
- R5: Rank runs from ID 7 (highest) down to ID 0, then from ID 15 down to ID 8. The device wins when no data line of higher rank than `ownId` is asserted at the decision point.
- R6: A winner sets `arbGrant` and keeps BUSY and its ID line driven until `arbReq` falls. One cycle after `arbReq` falls, all enables and the grant are 0.
- R7: A loser clears both drive enables and leaves `arbGrant` at 0 in the cycle after the decision. It then returns to monitoring, with no drive while idle.
- R8: When the device wins, every asserted ID of lower rank than `ownId` is recorded in the fairness register. A request is withheld, with no drive at all, while any ID remains recorded.
- R9: When BUSY is seen asserted by others on a free bus, the data lines are read ARB_CYC+1 cycles later. Only the highest-ranked asserted ID in that reading is removed from the fairness register.
- R10: While `rst` is 1, all drive enables and the grant are 0 from the next edge on, and the fairness register is emptied.
- R11: SELECT asserted on its own, with BUSY released, keeps the bus from being free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arbReq | input | 1 | Bus request from the local sequencer |
| ownId | input | 4 | This device's identifier |
| bsyInN | input | 1 | Sampled BUSY line, low = asserted |
| selInN | input | 1 | Sampled SELECT line, low = asserted |
| dbInN | input | 16 | Sampled data lines, low = asserted |
| arbGrant | output | 1 | Arbitration won; bus held |
| bsyDrvEn | output | 1 | Pull BUSY low |
| dbDrvEn | output | 16 | Pull the selected data line low |

## Verification
The core check runs arbitrations against contender sets built to separate the two halves of the ranking. Cases include ID 0 against ID 15, ID 8 against ID 9, a lone device, and a device with every other line asserted, so that both a plain numeric comparison and a reversed half order give wrong winners. Bus-free detection is tested with a clean release, a one-cycle BUSY glitch just short of the settle count, and SELECT held alone. These cases tell an exact settle count apart from an off-by-one error and from logic that ignores SELECT. Fairness is tested by watching one foreign arbitration that a higher-ranked ID wins, which must leave the hold in place, and then one that the recorded ID wins, which must release it.

// File: rtl/arbPkg.sv
package arbPkg;
  parameter int ARB_ID_W = 4;
  localparam int ARB_IDS = 1 << ARB_ID_W;
  localparam int ARB_HALF = ARB_IDS / 2;

  typedef logic [ARB_IDS-1:0] idMask_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARB   = 2'd1,
    ST_WATCH = 2'd2,
    ST_GRANT = 2'd3
  } arbState_t;

  // control -> datapath
  typedef struct packed {
    logic timerStart;
    logic driveId;
    logic judgeOwn;
    logic judgeOther;
  } arbStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic busFree;
    logic timerDone;
    logic ownWins;
    logic fairHold;
    logic bsyLow;
  } arbStatus_t;

  // lower half outranks upper half; inside each half the larger ID outranks
  function automatic int rankOf(input int id);
    return (id < ARB_HALF) ? id + ARB_HALF : id - ARB_HALF;
  endfunction

  function automatic idMask_t aboveMask(input int id);
    idMask_t m;
    for (int k = 0; k < ARB_IDS; k++) m[k] = rankOf(k) > rankOf(id);
    return m;
  endfunction
endpackage

// File: rtl/arbDatapath.sv
module arbDatapath
  import arbPkg::*;
#(
  parameter int SETTLE_CYC = 8,
  parameter int ARB_CYC    = 48
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bsyInN,
  input  logic                selInN,
  input  idMask_t             dbInN,
  input  logic [ARB_ID_W-1:0] ownId,
  input  arbStrobe_t          strobe,
  output arbStatus_t          stat,
  output idMask_t             dbDrvEn
);
  localparam int FREE_W = $clog2(SETTLE_CYC + 1);
  localparam int TMR_W  = $clog2(ARB_CYC + 1);
  localparam logic [FREE_W-1:0] FREE_MAX = FREE_W'(SETTLE_CYC);
  localparam logic [TMR_W-1:0]  TMR_MAX  = TMR_W'(ARB_CYC);

  logic [FREE_W-1:0] freeCnt;
  logic [TMR_W-1:0]  tmr;
  idMask_t           fairMask;
  idMask_t           seen;
  idMask_t           aboveOwn;
  idMask_t           lowerOwn;
  idMask_t           ownBit;
  idMask_t           topMask;

  assign seen     = ~dbInN;
  assign ownBit   = idMask_t'(1) << ownId;
  assign aboveOwn = aboveMask(int'(ownId));
  assign lowerOwn = ~aboveOwn & ~ownBit;

  // highest-ranked asserted ID on the bus
  always_comb begin
    for (int i = 0; i < ARB_IDS; i++)
      topMask[i] = seen[i] && ((seen & aboveMask(i)) == '0);
  end

  // settle counter: both control lines released
  always_ff @(posedge clk) begin
    if (rst) freeCnt <= '0;
    else if (bsyInN && selInN) begin
      if (freeCnt != FREE_MAX) freeCnt <= freeCnt + 1'b1;
    end else freeCnt <= '0;
  end

  // arbitration-window timer
  always_ff @(posedge clk) begin
    if (rst) tmr <= '0;
    else if (strobe.timerStart) tmr <= '0;
    else if (tmr != TMR_MAX) tmr <= tmr + 1'b1;
  end

  // fairness register
  always_ff @(posedge clk) begin
    if (rst) fairMask <= '0;
    else if (strobe.judgeOwn && stat.ownWins) fairMask <= fairMask | (seen & lowerOwn);
    else if (strobe.judgeOther) fairMask <= fairMask & ~topMask;
  end

  assign stat.busFree   = (freeCnt == FREE_MAX);
  assign stat.timerDone = (tmr == TMR_MAX);
  assign stat.ownWins   = ((seen & aboveOwn) == '0);
  assign stat.fairHold  = |fairMask;
  assign stat.bsyLow    = ~bsyInN;

  assign dbDrvEn = strobe.driveId ? ownBit : '0;

  // R1: a free indication always follows an edge with both lines released
  p_free_after_release_r1: assert property (@(posedge clk) disable iff (rst)
    stat.busFree |-> $past(bsyInN && selInN));

  // R8: only lower-ranked IDs get recorded on a win
  p_record_lower_r8: assert property (@(posedge clk) disable iff (rst)
    (strobe.judgeOwn && stat.ownWins) |=> ((fairMask & $past(aboveOwn | ownBit)) == ($past(fairMask) & $past(aboveOwn | ownBit))));
endmodule

// File: rtl/arbControl.sv
module arbControl
  import arbPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       arbReq,
  input  arbStatus_t stat,
  output arbStrobe_t strobe,
  output logic       bsyDrvEn,
  output logic       arbGrant
);
  arbState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (stat.busFree && arbReq && !stat.fairHold) begin
          nextState         = ST_ARB;
          strobe.timerStart = 1'b1;
        end else if (stat.busFree && stat.bsyLow) begin
          nextState         = ST_WATCH;
          strobe.timerStart = 1'b1;
        end
      end
      ST_ARB: begin
        strobe.driveId = 1'b1;
        if (stat.timerDone) begin
          strobe.judgeOwn = 1'b1;
          nextState       = stat.ownWins ? ST_GRANT : ST_IDLE;
        end
      end
      ST_WATCH: begin
        if (stat.timerDone) begin
          strobe.judgeOther = 1'b1;
          nextState         = ST_IDLE;
        end
      end
      ST_GRANT: begin
        strobe.driveId = 1'b1;
        if (!arbReq) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign bsyDrvEn = (state == ST_ARB) || (state == ST_GRANT);
  assign arbGrant = (state == ST_GRANT);

  // R1: driving starts only right after a free bus was seen
  p_start_on_free_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(bsyDrvEn) |-> $past(stat.busFree));

  // R8: no arbitration while the fairness register holds an ID
  p_fair_defer_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(bsyDrvEn) |-> $past(!stat.fairHold));

  // R6: withdrawn request releases the bus next cycle
  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    (arbGrant && !arbReq) |=> (!bsyDrvEn && !arbGrant));

  // R7: a lost decision releases everything
  p_loss_release_r7: assert property (@(posedge clk) disable iff (rst)
    (strobe.judgeOwn && !stat.ownWins) |=> (!bsyDrvEn && !arbGrant));

  // R10: reset clears the drives within one edge
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (!bsyDrvEn && !arbGrant));
endmodule

// File: rtl/busArbiter.sv
module busArbiter
  import arbPkg::*;
#(
  parameter int SETTLE_CYC = 8,
  parameter int ARB_CYC    = 48
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                arbReq,
  input  logic [ARB_ID_W-1:0] ownId,
  input  logic                bsyInN,
  input  logic                selInN,
  input  logic [ARB_IDS-1:0]  dbInN,
  output logic                arbGrant,
  output logic                bsyDrvEn,
  output logic [ARB_IDS-1:0]  dbDrvEn
);
  arbStrobe_t strobe;
  arbStatus_t stat;

  arbDatapath #(.SETTLE_CYC(SETTLE_CYC), .ARB_CYC(ARB_CYC)) u_dp (
    .clk(clk), .rst(rst), .bsyInN(bsyInN), .selInN(selInN), .dbInN(dbInN),
    .ownId(ownId), .strobe(strobe), .stat(stat), .dbDrvEn(dbDrvEn)
  );

  arbControl u_ctl (
    .clk(clk), .rst(rst), .arbReq(arbReq), .stat(stat), .strobe(strobe),
    .bsyDrvEn(bsyDrvEn), .arbGrant(arbGrant)
  );

  // R3: an ID line is driven only together with BUSY
  p_id_with_bsy_r3: assert property (@(posedge clk) disable iff (rst)
    (dbDrvEn != '0) |-> bsyDrvEn);
endmodule

// File: tb/busArbiter_tb.sv
module busArbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 3;
  localparam int ARBW   = 5;

  typedef struct packed {
    logic [3:0]  own;
    logic [15:0] ext;
    logic        win;
  } vec_t;

  // ranking 7..0 then 15..8 (R5)
  localparam vec_t VECS [9] = '{
    '{4'd7,  16'hFF7F, 1'b1},
    '{4'd0,  16'h8000, 1'b1},
    '{4'd15, 16'h0001, 1'b0},
    '{4'd8,  16'h0200, 1'b0},
    '{4'd9,  16'h0100, 1'b1},
    '{4'd3,  16'h0010, 1'b0},
    '{4'd4,  16'h0008, 1'b1},
    '{4'd12, 16'h0000, 1'b1},
    '{4'd6,  16'h0080, 1'b0}
  };

  logic clk = 0;
  logic rst = 1;
  logic arbReq = 0;
  logic [3:0] ownId = 0;
  logic extBsy = 0, extSel = 0;
  logic [15:0] extDb = 0;
  logic arbGrant, bsyDrvEn;
  logic [15:0] dbDrvEn;
  logic bsyInN, selInN;
  logic [15:0] dbInN;
  int nRun = 0, nFail = 0;
  bit done = 0;

  // wired-OR bus, active low (R2)
  assign bsyInN = ~(bsyDrvEn | extBsy);
  assign selInN = ~extSel;
  assign dbInN  = ~(dbDrvEn | extDb);

  always #(CLK_PERIOD/2) clk = ~clk;

  busArbiter #(.SETTLE_CYC(SETTLE), .ARB_CYC(ARBW)) u_dut (
    .clk(clk), .rst(rst), .arbReq(arbReq), .ownId(ownId), .bsyInN(bsyInN),
    .selInN(selInN), .dbInN(dbInN), .arbGrant(arbGrant), .bsyDrvEn(bsyDrvEn),
    .dbDrvEn(dbDrvEn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1; cyc(1); rst = 0;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    cyc(2);
    // R10: reset state
    chk("R10 reset bsy", bsyDrvEn, 0);
    chk("R10 reset db", dbDrvEn, 0);
    chk("R10 reset grant", arbGrant, 0);
    rst = 0;

    // table-driven arbitrations (R3 R4 R5 R6 R7)
    for (int v = 0; v < 9; v++) begin
      doReset();
      ownId = VECS[v].own; extBsy = 0; extDb = 0; arbReq = 1;
      cyc(SETTLE + 1);
      chk("R3 bsy drive", bsyDrvEn, 1);
      chk("R3 id drive", dbDrvEn, 32'(16'h1 << VECS[v].own));
      extDb = VECS[v].ext; extBsy = 1;
      cyc(ARBW);
      chk("R4 window held", {bsyDrvEn, arbGrant}, 2'b10);
      cyc(1);
      chk("R5 winner", arbGrant, VECS[v].win);
      chk("R6/R7 bsy after decision", bsyDrvEn, VECS[v].win);
      chk("R6/R7 id after decision", dbDrvEn, VECS[v].win ? 32'(16'h1 << VECS[v].own) : 0);
      arbReq = 0; cyc(1);
      extBsy = 0; extDb = 0;
    end

    // R1: exact settle count
    doReset();
    ownId = 2; extBsy = 1; arbReq = 1;
    cyc(4);
    chk("R1 busy no drive", bsyDrvEn, 0);
    extBsy = 0;
    cyc(SETTLE);
    chk("R1 before settle", bsyDrvEn, 0);
    cyc(1);
    chk("R1 after settle", bsyDrvEn, 1);

    // R11: SELECT alone holds the bus
    doReset();
    arbReq = 1; extSel = 1;
    cyc(20);
    chk("R11 sel holds bus", bsyDrvEn, 0);
    extSel = 0;
    cyc(SETTLE + 1);
    chk("R11 after sel release", bsyDrvEn, 1);

    // R1: glitch restarts the count; then R6 release
    doReset();
    extSel = 0; extBsy = 1; arbReq = 1;
    cyc(1);
    extBsy = 0; cyc(SETTLE - 1);
    extBsy = 1; cyc(1);
    extBsy = 0; cyc(SETTLE);
    chk("R1 glitch restart", bsyDrvEn, 0);
    cyc(1);
    chk("R1 glitch then drive", bsyDrvEn, 1);
    cyc(ARBW + 1);
    chk("R6 lone grant", arbGrant, 1);
    arbReq = 0; cyc(1);
    chk("R6 release", {arbGrant, bsyDrvEn, (dbDrvEn != 0)}, 3'b000);

    // R8 / R9: fairness
    doReset();
    ownId = 3; arbReq = 1;
    cyc(SETTLE + 1);
    extDb = 16'h0002; extBsy = 1;
    cyc(ARBW + 1);
    chk("R8 win with lower contender", arbGrant, 1);
    arbReq = 0; cyc(1);
    extBsy = 0; extDb = 0; arbReq = 1;
    cyc(SETTLE + 6);
    chk("R8 request withheld", {bsyDrvEn, (dbDrvEn != 0)}, 2'b00);
    extBsy = 1; extDb = 16'h0022;   // ID5 outranks ID1
    cyc(ARBW + 3);
    extBsy = 0; extDb = 0;
    cyc(SETTLE + 6);
    chk("R9 other winner keeps hold", bsyDrvEn, 0);
    extBsy = 1; extDb = 16'h0002;   // ID1 wins
    cyc(ARBW + 3);
    extBsy = 0; extDb = 0;
    cyc(SETTLE);
    chk("R9 before settle", bsyDrvEn, 0);
    cyc(1);
    chk("R9 hold cleared", bsyDrvEn, 1);

    // R10: reset mid-grant and fairness cleared
    doReset();
    ownId = 1; arbReq = 1;
    cyc(SETTLE + 1);
    extDb = 16'h0001; extBsy = 1;
    cyc(ARBW + 1);
    chk("R10 pre grant", arbGrant, 1);
    rst = 1; extBsy = 0; extDb = 0;
    cyc(1);
    chk("R10 reset in grant", {arbGrant, bsyDrvEn, (dbDrvEn != 0)}, 3'b000);
    rst = 0;
    cyc(SETTLE + 1);
    chk("R10 fairness cleared", bsyDrvEn, 1);

    done = 1;
    finishRun();
  end
endmodule